// File: doc/BRIEF.md
# Delay-Slot Program Counter Controller

This block owns the program counter of a 32-bit core that executes exactly one instruction after every control transfer (a single delay slot). Each cycle in which `issue` is high, the instruction at `pc` is taken as executed. The decoder presents that instruction's control-transfer class, a likely flag, both source register values and an already computed target address. The block then sequences the PC, tells the pipeline when the delay-slot instruction must be annulled, and produces the link-register write for jump-and-link.

Three conditional tests are supported: signed greater-than-zero, signed less-than-or-equal-zero, and byte-lane match, which is true when any of the four byte lanes of the two operands are equal. Each test has a normal form and a likely form. A taken transfer of any kind lets the next instruction execute and then redirects. A normal branch that is not taken just falls through. A likely branch that is not taken annuls the one instruction that follows it.

The controller is a three-state machine. `ST_SEQ` is sequential execution. `ST_SLOT_GO` is a delay slot with a redirect pending. `ST_SLOT_KILL` is a delay slot being annulled. The transitions are named as follows:
- SEQ->SLOT_GO: an issued transfer is taken.
- SEQ->SLOT_KILL: an issued likely branch is not taken.
- SEQ->SEQ: any other issued instruction.
- SLOT_GO->SEQ: the delay slot issues, and the PC loads the held target.
- SLOT_KILL->SEQ: the annulled slot issues, and the PC steps by 4.

In every state, a cycle without `issue` holds all state.

Top module: `dslot_pc_ctrl`

## Requirements
- R1: While `rst_n` is low, `pc` equals the reset address (default 0x00000100), `annul` is 0 and `link_we` is 0.
- R2: With no redirect pending, each issued instruction advances `pc` by 4. A cycle with `issue` low leaves `pc` and `annul` unchanged.
- R3: A taken transfer issued at address P moves `pc` to P+4 on that issue. The next issue (the delay slot) loads `pc` with the target that was presented alongside the transfer.
- R4: `br_op` encoding: 0 none, 1 greater-than-zero, 2 less-or-equal-zero, 3 byte-lane match, 4 jump, 5 jump-and-link; codes 6 and 7 act as none. The two zero tests compare `rs_val` as a signed 32-bit number.
- R5: The byte-lane match branch is taken when `rs_val` and `rt_val` agree in at least one of the four 8-bit lanes.
- R6: A normal conditional branch that is not taken issues its delay slot with `annul` low. `pc` then runs P+4, P+8.
- R7: A likely conditional branch (`likely` = 1, op 1..3) that is not taken raises `annul` while `pc` is P+4. `annul` stays high until that slot issues, then drops as `pc` becomes P+8.
- R8: A taken likely branch behaves as a taken normal branch, and `annul` stays low.
- R9: Ops 4 and 5 always redirect after one delay slot, and `likely` has no effect on them. During the issue cycle of op 5, `link_we` is high, `link_idx` is 31 and `link_data` is P+8.
- R10: An instruction issued in a delay slot, whether executed or annulled, starts no transfer and makes no link write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Instruction at `pc` executes this cycle |
| br_op | input | 3 | Control-transfer class of the issued instruction |
| likely | input | 1 | Likely form of a conditional branch |
| rs_val | input | 32 | First source register value |
| rt_val | input | 32 | Second source register value (byte match) |
| target | input | 32 | Computed transfer target |
| pc | output | 32 | Address of the current instruction |
| annul | output | 1 | Instruction at `pc` is an annulled delay slot |
| link_we | output | 1 | Link register write enable |
| link_idx | output | 5 | Link register index |
| link_data | output | 32 | Return address for the link write |

## Verification
A state machine stuck in or wrongly entering `ST_SLOT_GO` shows up at the very next issue, as `pc` loading a stale target instead of stepping by 4. A wrong entry into `ST_SLOT_KILL` raises `annul` in the cycle right after the branch issues. A lost pending target or a condition evaluated on the wrong sign shows on `pc` after exactly two issues. Nested transfers in a slot and stalls inside a slot are driven on purpose, because those are the cases where a wrong state persists instead of recovering.

// File: rtl/dslot_pc_pkg.sv
package dslot_pc_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_GTZ  = 3'd1,
        OP_LEZ  = 3'd2,
        OP_BMB  = 3'd3,
        OP_JUMP = 3'd4,
        OP_JAL  = 3'd5
    } br_op_e;

    typedef enum logic [1:0] {
        ST_SEQ       = 2'd0,
        ST_SLOT_GO   = 2'd1,
        ST_SLOT_KILL = 2'd2
    } pc_state_e;

endpackage

// File: rtl/dslot_cond_eval.sv
module dslot_cond_eval
    import dslot_pc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int LANE_W = 8
) (
    input  logic [2:0]      op,
    input  logic            likely,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    output logic            take,
    output logic            kill,
    output logic            is_link
);
    localparam int LANES = XLEN / LANE_W;

    logic [LANES-1:0] lane_eq;
    logic             any_lane;
    logic             is_cond;
    logic             cond_ok;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_eq[g] = (rs_val[g*LANE_W +: LANE_W] == rt_val[g*LANE_W +: LANE_W]);
    end

    assign any_lane = |lane_eq;

    always_comb begin
        is_cond = 1'b0;
        cond_ok = 1'b0;
        is_link = 1'b0;
        take    = 1'b0;
        unique case (op)
            OP_GTZ: begin
                is_cond = 1'b1;
                cond_ok = ($signed(rs_val) > 0);
            end
            OP_LEZ: begin
                is_cond = 1'b1;
                cond_ok = ($signed(rs_val) <= 0);
            end
            OP_BMB: begin
                is_cond = 1'b1;
                cond_ok = any_lane;
            end
            OP_JUMP: take = 1'b1;
            OP_JAL: begin
                take    = 1'b1;
                is_link = 1'b1;
            end
            default: ;
        endcase
        if (is_cond) begin
            take = cond_ok;
        end
        kill = is_cond && likely && !cond_ok;
    end

endmodule

// File: rtl/dslot_seq_fsm.sv
module dslot_seq_fsm
    import dslot_pc_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter int              INSN_BYTES = 4,
    parameter logic [XLEN-1:0] RESET_PC   = 32'h0000_0100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue,
    input  logic            take,
    input  logic            kill,
    input  logic            is_link,
    input  logic [XLEN-1:0] target,
    output logic [XLEN-1:0] pc,
    output logic            annul,
    output logic            link_we,
    output logic [XLEN-1:0] link_data,
    output pc_state_e       state,
    output logic [XLEN-1:0] pend_tgt
);
    localparam logic [XLEN-1:0] STEP     = XLEN'(INSN_BYTES);
    localparam logic [XLEN-1:0] LINK_OFS = XLEN'(2 * INSN_BYTES);

    pc_state_e       state_q, state_d;
    logic [XLEN-1:0] pc_q, pc_d;
    logic [XLEN-1:0] tgt_q, tgt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SEQ;
            pc_q    <= RESET_PC;
            tgt_q   <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            tgt_q   <= tgt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        tgt_d   = tgt_q;
        if (issue) begin
            unique case (state_q)
                ST_SEQ: begin
                    pc_d = pc_q + STEP;
                    if (take) begin
                        state_d = ST_SLOT_GO;
                        tgt_d   = target;
                    end else if (kill) begin
                        state_d = ST_SLOT_KILL;
                    end
                end
                ST_SLOT_GO: begin
                    pc_d    = tgt_q;
                    state_d = ST_SEQ;
                end
                ST_SLOT_KILL: begin
                    pc_d    = pc_q + STEP;
                    state_d = ST_SEQ;
                end
                default: begin
                    state_d = ST_SEQ;
                end
            endcase
        end
    end

    always_comb begin
        annul     = (state_q == ST_SLOT_KILL);
        link_we   = issue && (state_q == ST_SEQ) && is_link;
        link_data = pc_q + LINK_OFS;
    end

    assign pc       = pc_q;
    assign state    = state_q;
    assign pend_tgt = tgt_q;

endmodule

// File: rtl/dslot_pc_ctrl.sv
module dslot_pc_ctrl
    import dslot_pc_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter int              LANE_W     = 8,
    parameter int              INSN_BYTES = 4,
    parameter int              REG_IDX_W  = 5,
    parameter int              LINK_REG   = 31,
    parameter logic [XLEN-1:0] RESET_PC   = 32'h0000_0100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue,
    input  logic [2:0]           br_op,
    input  logic                 likely,
    input  logic [XLEN-1:0]      rs_val,
    input  logic [XLEN-1:0]      rt_val,
    input  logic [XLEN-1:0]      target,
    output logic [XLEN-1:0]      pc,
    output logic                 annul,
    output logic                 link_we,
    output logic [REG_IDX_W-1:0] link_idx,
    output logic [XLEN-1:0]      link_data
);
    logic            take;
    logic            kill;
    logic            is_link;
    pc_state_e       fsm_state;
    logic [XLEN-1:0] fsm_pend;

    dslot_cond_eval #(
        .XLEN   (XLEN),
        .LANE_W (LANE_W)
    ) u_cond (
        .op      (br_op),
        .likely  (likely),
        .rs_val  (rs_val),
        .rt_val  (rt_val),
        .take    (take),
        .kill    (kill),
        .is_link (is_link)
    );

    dslot_seq_fsm #(
        .XLEN       (XLEN),
        .INSN_BYTES (INSN_BYTES),
        .RESET_PC   (RESET_PC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (issue),
        .take      (take),
        .kill      (kill),
        .is_link   (is_link),
        .target    (target),
        .pc        (pc),
        .annul     (annul),
        .link_we   (link_we),
        .link_data (link_data),
        .state     (fsm_state),
        .pend_tgt  (fsm_pend)
    );

    assign link_idx = REG_IDX_W'(LINK_REG);

endmodule

// File: rtl/dslot_pc_ctrl_chk.sv
module dslot_pc_ctrl_chk
    import dslot_pc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            issue,
    input logic [2:0]      br_op,
    input logic [XLEN-1:0] pc,
    input logic            annul,
    input logic            link_we,
    input pc_state_e       state,
    input logic [XLEN-1:0] pend_tgt
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    AST_HOLD_PC: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> $stable(pc)); // R2
    AST_HOLD_ANNUL: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> $stable(annul)); // R2
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && state == ST_SEQ && br_op == 3'd0) |=> (pc == $past(pc) + STEP)); // R2
    AST_SLOT_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && state == ST_SLOT_GO) |=> (pc == $past(pend_tgt))); // R3
    AST_ANNUL_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (annul && issue) |=> !annul); // R7
    AST_KILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && annul) |=> (pc == $past(pc) + STEP)); // R7
    AST_LINK_REDIRECTS: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |=> (state == ST_SLOT_GO)); // R9
    AST_SLOT_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SEQ) |-> !link_we); // R10
    AST_JUMP_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && state == ST_SEQ && (br_op == 3'd4 || br_op == 3'd5)) |=> (state == ST_SLOT_GO)); // R9

endmodule

bind dslot_pc_ctrl dslot_pc_ctrl_chk #(
    .XLEN       (XLEN),
    .INSN_BYTES (INSN_BYTES)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (issue),
    .br_op    (br_op),
    .pc       (pc),
    .annul    (annul),
    .link_we  (link_we),
    .state    (fsm_state),
    .pend_tgt (fsm_pend)
);

// File: tb/dslot_pc_ctrl_tb_top.sv
module dslot_pc_ctrl_tb_top;

    localparam logic [31:0] RST_PC = 32'h0000_0100;

    typedef struct packed {
        logic [2:0]  op;
        logic        lk;
        logic [31:0] a;
        logic [31:0] b;
        logic        tk;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 1'b0, 32'h0000_0005, 32'h0, 1'b1},
        '{3'd1, 1'b0, 32'h0000_0000, 32'h0, 1'b0},
        '{3'd1, 1'b0, 32'h8000_0000, 32'h0, 1'b0},
        '{3'd2, 1'b0, 32'h0000_0000, 32'h0, 1'b1},
        '{3'd2, 1'b0, 32'hFFFF_FFFF, 32'h0, 1'b1},
        '{3'd2, 1'b0, 32'h7FFF_FFFF, 32'h0, 1'b0},
        '{3'd1, 1'b1, 32'h0000_0000, 32'h0, 1'b0},
        '{3'd2, 1'b1, 32'hFFFF_FFFF, 32'h0, 1'b1},
        '{3'd3, 1'b0, 32'h1122_3344, 32'h5566_3377, 1'b1},
        '{3'd3, 1'b0, 32'h0102_0304, 32'h0506_0708, 1'b0},
        '{3'd3, 1'b1, 32'hAABB_CCDD, 32'hAA00_0000, 1'b1},
        '{3'd3, 1'b1, 32'h1234_5678, 32'h8765_4321, 1'b0},
        '{3'd4, 1'b1, 32'h0000_0000, 32'h0, 1'b1},
        '{3'd5, 1'b0, 32'h8000_0000, 32'h0, 1'b1},
        '{3'd6, 1'b1, 32'h0000_0005, 32'h0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [2:0]  br_op = 3'd0;
    logic        likely = 1'b0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [31:0] target = '0;
    logic [31:0] pc;
    logic        annul;
    logic        link_we;
    logic [4:0]  link_idx;
    logic [31:0] link_data;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    logic [31:0] mpc;

    always #2 clk = ~clk;

    dslot_pc_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (issue),
        .br_op     (br_op),
        .likely    (likely),
        .rs_val    (rs_val),
        .rt_val    (rt_val),
        .target    (target),
        .pc        (pc),
        .annul     (annul),
        .link_we   (link_we),
        .link_idx  (link_idx),
        .link_data (link_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic iss, input logic [2:0] op, input logic lk,
                         input logic [31:0] a, input logic [31:0] b, input logic [31:0] t);
        @(negedge clk);
        issue = iss; br_op = op; likely = lk; rs_val = a; rt_val = b; target = t;
        #1;
    endtask

    task automatic edge_settle();
        @(posedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset pc", pc, RST_PC);
        chk("R1 reset annul", 32'(annul), 32'd0);
        chk("R1 reset link_we", 32'(link_we), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        mpc = RST_PC;

        // R2: idle cycles hold, then sequential step
        drive(1'b0, 3'd0, 1'b0, 0, 0, 0);
        edge_settle();
        edge_settle();
        chk("R2 hold pc", pc, mpc);
        drive(1'b1, 3'd0, 1'b0, 0, 0, 0);
        edge_settle();
        mpc = mpc + 4;
        chk("R2 step pc", pc, mpc);

        // table walk: R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            logic [31:0] tgt;
            logic        exp_an;
            logic        exp_lk;
            tgt    = 32'h0000_2000 + 32'(i) * 32'h40;
            exp_an = VECS[i].lk && !VECS[i].tk && (VECS[i].op >= 3'd1) && (VECS[i].op <= 3'd3);
            exp_lk = (VECS[i].op == 3'd5);
            drive(1'b1, VECS[i].op, VECS[i].lk, VECS[i].a, VECS[i].b, tgt);
            chk($sformatf("R9 link_we v%0d", i), 32'(link_we), 32'(exp_lk));
            if (exp_lk) begin
                chk("R9 link_data", link_data, mpc + 8);
                chk("R9 link_idx", 32'(link_idx), 32'd31);
            end
            edge_settle();
            chk($sformatf("R3 slot pc v%0d", i), pc, mpc + 4);
            chk($sformatf("R7 annul v%0d", i), 32'(annul), 32'(exp_an));
            drive(1'b1, 3'd0, 1'b0, 0, 0, 0);
            edge_settle();
            mpc = VECS[i].tk ? tgt : mpc + 8;
            chk($sformatf("R4 R5 R6 R8 after-slot pc v%0d", i), pc, mpc);
            chk($sformatf("R7 annul cleared v%0d", i), 32'(annul), 32'd0);
        end

        // R10: jump-and-link inside an executed delay slot is ignored
        drive(1'b1, 3'd4, 1'b0, 0, 0, 32'h0000_4000);
        edge_settle();
        drive(1'b1, 3'd5, 1'b0, 0, 0, 32'h0000_5000);
        chk("R10 no link in slot", 32'(link_we), 32'd0);
        edge_settle();
        chk("R10 first target kept", pc, 32'h0000_4000);
        drive(1'b1, 3'd0, 1'b0, 0, 0, 0);
        edge_settle();
        chk("R10 no nested redirect", pc, 32'h0000_4004);
        mpc = 32'h0000_4004;

        // R10 + R7: annulled slot carrying a jump is ignored
        drive(1'b1, 3'd1, 1'b1, 32'h0, 0, 32'h0000_6000);
        edge_settle();
        drive(1'b1, 3'd5, 1'b0, 0, 0, 32'h0000_7000);
        chk("R10 no link in killed slot", 32'(link_we), 32'd0);
        edge_settle();
        chk("R10 killed slot falls through", pc, mpc + 8);
        mpc = mpc + 8;

        // R7: stall inside a killed slot keeps annul high
        drive(1'b1, 3'd2, 1'b1, 32'h0000_0001, 0, 32'h0000_8000);
        edge_settle();
        drive(1'b0, 3'd0, 1'b0, 0, 0, 0);
        edge_settle();
        edge_settle();
        chk("R7 annul held in stall", 32'(annul), 32'd1);
        chk("R2 pc held in stall", pc, mpc + 4);
        drive(1'b1, 3'd0, 1'b0, 0, 0, 0);
        edge_settle();
        chk("R7 annul drops", 32'(annul), 32'd0);
        chk("R7 pc after stall", pc, mpc + 8);
        mpc = mpc + 8;

        // R3: stall inside a taken slot keeps the target
        drive(1'b1, 3'd3, 1'b0, 32'hDEAD_BEEF, 32'h0000_00EF, 32'h0000_9000);
        edge_settle();
        drive(1'b0, 3'd4, 1'b0, 0, 0, 32'h0000_A000);
        edge_settle();
        edge_settle();
        chk("R3 pc held in taken slot", pc, mpc + 4);
        drive(1'b1, 3'd0, 1'b0, 0, 0, 32'h0000_B000);
        edge_settle();
        chk("R3 target after stall", pc, 32'h0000_9000);

        // R1: reset with a redirect pending
        drive(1'b1, 3'd4, 1'b0, 0, 0, 32'h0000_C000);
        edge_settle();
        @(negedge clk);
        rst_n = 1'b0;
        issue = 1'b0;
        edge_settle();
        chk("R1 mid-run reset pc", pc, RST_PC);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 3'd0, 1'b0, 0, 0, 0);
        edge_settle();
        chk("R1 pending target dropped", pc, RST_PC + 4);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule